// File: doc/BRIEF.md
# Narrow Shared-Line Address/Data Link

This block joins a sending port and a receiving port over a narrow set of shared lines. The lines carry the address first and the data afterwards, cut into pieces that are narrower than either word. The sending side takes a command: single or block, a start address, and for a block a word count. It breaks the address and each data word into pieces, lowest piece first, and drives one piece per clock beat. The receiving side holds the address in its own register, because the lines are reused for data, and rebuilds each data word. Once a word is whole it presents the word as a one-cycle write with its address.

A single transfer always takes the address pieces followed by the data pieces. A block transfer sends its start address once. From then on, a second set of lines, which stays idle during address beats and single transfers, carries the upper half of every data beat, so each beat moves twice as many data bits. The receiver advances its held address by one word after each word it completes in block mode. Each beat is tagged as address or data, a mode line marks the address beats of a block transfer, and a last-beat line closes every transfer.

Top module: `mxb_link`

## Requirements
- R1: After reset, bus_valid and wr_valid are low and cmd_ready is high.
- R2: Every transfer starts with exactly AW/BW beats with bus_is_addr high. No address beat follows a data beat of the same transfer.
- R3: Address pieces appear on bus_ad lowest piece first. Piece k carries address bits [k*BW+BW-1 : k*BW].
- R4: A single transfer has exactly DW/BW data beats, lowest piece first on bus_ad, and bus_ext is zero on those beats.
- R5: For a single transfer, the receiver raises wr_valid for one cycle, with wr_addr equal to the sent address and wr_data equal to the sent word.
- R6: A block data beat carries data bits [2k*BW+BW-1 : 2k*BW] on bus_ad and the next BW bits on bus_ext, so each word takes DW/(2*BW) beats. bus_ext is zero on every address beat.
- R7: In a block of N words, word i is written at start address + i, modulo 2^AW.
- R8: bus_last is high on exactly one beat per transfer: the final data beat.
- R9: A block command with cmd_len of 0 moves one word. A single command ignores cmd_len and moves one word.
- R10: cmd_ready is low while a transfer is on the lines, and cmd_valid is ignored then. No extra beats or writes occur.
- R11: data_take is high for one cycle per word consumed. data_in is captured at that clock edge.
- R12: bus_burst is high only on the address beats of a block transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present (taken when cmd_ready is high) |
| cmd_block | input | 1 | 1 = block transfer, 0 = single |
| cmd_addr | input | AW | Start word address |
| cmd_len | input | LW | Block word count (0 counts as 1) |
| cmd_ready | output | 1 | Sender idle, command accepted this cycle if valid |
| data_in | input | DW | Next data word for the sender |
| data_take | output | 1 | data_in is captured at this clock edge |
| bus_valid | output | 1 | Beat present on the shared lines |
| bus_is_addr | output | 1 | Beat is an address piece |
| bus_burst | output | 1 | Address beat of a block transfer |
| bus_last | output | 1 | Final beat of the transfer |
| bus_ad | output | BW | Shared address/data lines |
| bus_ext | output | BW | Extra lines, upper data half in block mode |
| wr_valid | output | 1 | Receiver commits one word |
| wr_addr | output | AW | Address of the committed word |
| wr_data | output | DW | Committed word |

## Verification
The assertions assume that commands arrive only through cmd_valid and cmd_ready. They also assume the sender's lines reach the receiver unchanged, so the shared-line rules can be checked at the top ports. The stimulus holds each data word on data_in until the edge where data_take is high, then moves to the next word. While a transfer is in flight, it keeps cmd_valid high with altered fields to test that busy commands are ignored. It drops cmd_valid on the final beat, so no stray command is accepted when the sender goes idle.

// File: rtl/mxb_link_pkg.sv
package mxb_link_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

endpackage

// File: rtl/mxb_sender.sv
module mxb_sender
    import mxb_link_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int BW = 4,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_block,
    input  logic [AW-1:0] cmd_addr,
    input  logic [LW-1:0] cmd_len,
    output logic          cmd_ready,
    input  logic [DW-1:0] data_in,
    output logic          data_take,
    output logic          bus_valid,
    output logic          bus_is_addr,
    output logic          bus_burst,
    output logic          bus_last,
    output logic [BW-1:0] bus_ad,
    output logic [BW-1:0] bus_ext
);
    localparam int AP  = AW / BW;
    localparam int SP  = DW / BW;
    localparam int BP  = DW / (2 * BW);
    localparam int PCW = $clog2(AP + SP);

    typedef struct packed {
        phase_e        ph;
        logic          blk;
        logic [PCW-1:0] pc;
        logic [LW-1:0] left;
        logic [AW-1:0] ash;
        logic [DW-1:0] dsh;
    } snd_t;

    snd_t q, d;
    logic last_piece;

    always_comb begin
        d          = q;
        data_take  = 1'b0;
        last_piece = (q.pc == (q.blk ? PCW'(BP - 1) : PCW'(SP - 1)));
        case (q.ph)
            PH_IDLE: begin
                if (cmd_valid) begin
                    d.ph      = PH_ADDR;
                    d.blk     = cmd_block;
                    d.pc      = '0;
                    d.left    = (cmd_block && cmd_len != '0) ? cmd_len : LW'(1);
                    d.ash     = cmd_addr;
                    d.dsh     = data_in;
                    data_take = 1'b1;
                end
            end
            PH_ADDR: begin
                d.ash = q.ash >> BW;
                if (q.pc == PCW'(AP - 1)) begin
                    d.ph = PH_DATA;
                    d.pc = '0;
                end else begin
                    d.pc = q.pc + PCW'(1);
                end
            end
            PH_DATA: begin
                d.dsh = q.blk ? (q.dsh >> (2 * BW)) : (q.dsh >> BW);
                if (last_piece) begin
                    d.pc = '0;
                    if (q.left > LW'(1)) begin
                        d.left    = q.left - LW'(1);
                        d.dsh     = data_in;
                        data_take = 1'b1;
                    end else begin
                        d.ph = PH_IDLE;
                    end
                end else begin
                    d.pc = q.pc + PCW'(1);
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ph: PH_IDLE, blk: 1'b0, pc: '0, left: '0, ash: '0, dsh: '0};
        end else begin
            q <= d;
        end
    end

    assign cmd_ready   = (q.ph == PH_IDLE);
    assign bus_valid   = (q.ph != PH_IDLE);
    assign bus_is_addr = (q.ph == PH_ADDR);
    assign bus_burst   = (q.ph == PH_ADDR) && q.blk;
    assign bus_last    = (q.ph == PH_DATA) && last_piece && (q.left == LW'(1));
    assign bus_ad      = (q.ph == PH_ADDR) ? q.ash[BW-1:0] : q.dsh[BW-1:0];
    assign bus_ext     = ((q.ph == PH_DATA) && q.blk) ? q.dsh[2*BW-1:BW] : '0;

endmodule

// File: rtl/mxb_receiver.sv
module mxb_receiver #(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_valid,
    input  logic          bus_is_addr,
    input  logic          bus_burst,
    input  logic [BW-1:0] bus_ad,
    input  logic [BW-1:0] bus_ext,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    localparam int AP  = AW / BW;
    localparam int SP  = DW / BW;
    localparam int BP  = DW / (2 * BW);
    localparam int PCW = $clog2(AP + SP);

    typedef struct packed {
        logic           blk;
        logic [PCW-1:0] pc;
        logic [AW-1:0]  adr;
        logic [DW-1:0]  acc;
        logic           wv;
        logic [AW-1:0]  wa;
        logic [DW-1:0]  wd;
    } rcv_t;

    rcv_t q, d;
    logic [DW-1:0] acc_next;
    logic          word_done;

    always_comb begin
        d         = q;
        d.wv      = 1'b0;
        acc_next  = q.blk ? ((q.acc >> (2 * BW)) | (DW'({bus_ext, bus_ad}) << (DW - 2 * BW)))
                          : ((q.acc >> BW) | (DW'(bus_ad) << (DW - BW)));
        word_done = (q.pc == (q.blk ? PCW'(BP - 1) : PCW'(SP - 1)));
        if (bus_valid) begin
            if (bus_is_addr) begin
                d.adr = (q.adr >> BW) | (AW'(bus_ad) << (AW - BW));
                d.blk = bus_burst;
                d.pc  = '0;
            end else begin
                d.acc = acc_next;
                if (word_done) begin
                    d.wv = 1'b1;
                    d.wa = q.adr;
                    d.wd = acc_next;
                    d.pc = '0;
                    if (q.blk) begin
                        d.adr = q.adr + AW'(1);
                    end
                end else begin
                    d.pc = q.pc + PCW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign wr_valid = q.wv;
    assign wr_addr  = q.wa;
    assign wr_data  = q.wd;

endmodule

// File: rtl/mxb_link.sv
module mxb_link #(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int BW = 4,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_block,
    input  logic [AW-1:0] cmd_addr,
    input  logic [LW-1:0] cmd_len,
    output logic          cmd_ready,
    input  logic [DW-1:0] data_in,
    output logic          data_take,
    output logic          bus_valid,
    output logic          bus_is_addr,
    output logic          bus_burst,
    output logic          bus_last,
    output logic [BW-1:0] bus_ad,
    output logic [BW-1:0] bus_ext,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);

    mxb_sender #(.AW(AW), .DW(DW), .BW(BW), .LW(LW)) u_snd (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_block   (cmd_block),
        .cmd_addr    (cmd_addr),
        .cmd_len     (cmd_len),
        .cmd_ready   (cmd_ready),
        .data_in     (data_in),
        .data_take   (data_take),
        .bus_valid   (bus_valid),
        .bus_is_addr (bus_is_addr),
        .bus_burst   (bus_burst),
        .bus_last    (bus_last),
        .bus_ad      (bus_ad),
        .bus_ext     (bus_ext)
    );

    mxb_receiver #(.AW(AW), .DW(DW), .BW(BW)) u_rcv (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_valid   (bus_valid),
        .bus_is_addr (bus_is_addr),
        .bus_burst   (bus_burst),
        .bus_ad      (bus_ad),
        .bus_ext     (bus_ext),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data)
    );

endmodule

// File: rtl/mxb_link_chk.sv
module mxb_link_chk #(
    parameter int BW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_ready,
    input logic          data_take,
    input logic          bus_valid,
    input logic          bus_is_addr,
    input logic          bus_burst,
    input logic          bus_last,
    input logic [BW-1:0] bus_ext
);

    assert_addr_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_valid) |-> bus_is_addr);

    assert_last_on_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_last |-> (bus_valid && !bus_is_addr));

    assert_last_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_last |=> !bus_valid);

    assert_busy_no_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> !cmd_ready);

    assert_ext_quiet_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_is_addr) |-> (bus_ext == '0));

    assert_burst_only_addr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_burst |-> (bus_valid && bus_is_addr));

    assert_take_feeds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        data_take |=> bus_valid);

endmodule

bind mxb_link mxb_link_chk #(.BW(BW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_ready   (cmd_ready),
    .data_take   (data_take),
    .bus_valid   (bus_valid),
    .bus_is_addr (bus_is_addr),
    .bus_burst   (bus_burst),
    .bus_last    (bus_last),
    .bus_ext     (bus_ext)
);

// File: tb/mxb_link_test.sv
module mxb_link_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int BW = 4;
    localparam int LW = 4;
    localparam int AP = AW / BW;
    localparam int SP = DW / BW;
    localparam int BP = DW / (2 * BW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_block = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [LW-1:0] cmd_len = '0;
    logic          cmd_ready;
    logic [DW-1:0] data_in = '0;
    logic          data_take;
    logic          bus_valid, bus_is_addr, bus_burst, bus_last;
    logic [BW-1:0] bus_ad, bus_ext;
    logic          wr_valid;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    logic [AW-1:0] wq_a[$];
    logic [DW-1:0] wq_d[$];
    logic [AW-1:0] fq_a[$];
    bit            fq_b[$];
    int            fq_w[$];
    logic [DW-1:0] feed[16];

    int            abeats = 0;
    int            dbeats = 0;
    logic [AW-1:0] aasm = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mxb_link #(.AW(AW), .DW(DW), .BW(BW), .LW(LW)) uut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 20000", cyc);
            finish_run();
        end
    end

    // Monitor: reconstructs each frame and compares committed writes.
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_valid) begin
                if (fq_a.size() == 0) begin
                    chk(1'b0, "R10", "beat with no command", 32'(bus_ad), 0);
                end else if (bus_is_addr) begin
                    chk(dbeats == 0, "R2", "address beat after data", dbeats, 0);
                    aasm = aasm | (AW'(bus_ad) << (abeats * BW));
                    abeats++;
                    chk(bus_ext == '0, "R6", "ext on address beat", 32'(bus_ext), 0);
                    chk(bus_burst == fq_b[0], "R12", "mode line on address beat",
                        32'(bus_burst), 32'(fq_b[0]));
                end else begin
                    chk(bus_burst == 1'b0, "R12", "mode line on data beat", 32'(bus_burst), 0);
                    if (!fq_b[0]) chk(bus_ext == '0, "R4", "ext on single data beat", 32'(bus_ext), 0);
                    dbeats++;
                end
                if (bus_last && fq_a.size() != 0) begin
                    chk(!bus_is_addr, "R8", "last on address beat", 32'(bus_is_addr), 0);
                    chk(aasm == fq_a[0], "R3", "address pieces", 32'(aasm), 32'(fq_a[0]));
                    chk(abeats == AP, "R2", "address beat count", abeats, AP);
                    chk(dbeats == fq_w[0], fq_b[0] ? "R6" : "R4", "data beat count",
                        dbeats, fq_w[0]);
                    void'(fq_a.pop_front());
                    void'(fq_b.pop_front());
                    void'(fq_w.pop_front());
                    abeats = 0;
                    dbeats = 0;
                    aasm   = '0;
                end
            end
            if (wr_valid) begin
                if (wq_a.size() == 0) begin
                    chk(1'b0, "R10", "unexpected write", 32'(wr_addr), 0);
                end else begin
                    chk(wr_addr == wq_a[0], "R7", "write address", 32'(wr_addr), 32'(wq_a[0]));
                    chk(wr_data == wq_d[0], "R5", "write data", 32'(wr_data), 32'(wq_d[0]));
                    void'(wq_a.pop_front());
                    void'(wq_d.pop_front());
                end
            end
        end
    end

    // Driver: pushes expectations, then feeds the command and data words.
    task automatic run_xfer(input bit blk, input logic [AW-1:0] addr, input logic [LW-1:0] len);
        int  words;
        int  idx;
        int  takes;
        bit  took;
        bit  done;
        words = (blk && len != 0) ? int'(len) : 1;
        for (int i = 0; i < words; i++) begin
            wq_a.push_back(addr + AW'(i));
            wq_d.push_back(feed[i]);
        end
        fq_a.push_back(addr);
        fq_b.push_back(blk);
        fq_w.push_back(blk ? words * BP : SP);
        idx   = 0;
        takes = 0;
        done  = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_block = blk;
        cmd_addr  = addr;
        cmd_len   = len;
        data_in   = feed[0];
        #1;
        while (!done) begin
            took = data_take;
            if (took) takes++;
            if (bus_last) begin
                cmd_valid = 1'b0;
                done      = 1'b1;
            end
            @(posedge clk);
            #1;
            // R10: altered command while busy must be ignored
            cmd_block = ~blk;
            cmd_addr  = ~addr;
            cmd_len   = LW'(7);
            if (took && idx < 15) begin
                idx++;
                data_in = feed[idx];
            end
            @(negedge clk);
            #1;
        end
        chk(takes == words, "R11", "data_take count", takes, words);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) feed[i] = DW'(16'hA50F ^ (i * 16'h1357));
        repeat (3) @(negedge clk);
        chk(bus_valid == 1'b0, "R1", "bus_valid after reset", 32'(bus_valid), 0);
        chk(wr_valid == 1'b0, "R1", "wr_valid after reset", 32'(wr_valid), 0);
        chk(cmd_ready == 1'b1, "R1", "cmd_ready after reset", 32'(cmd_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 R5 R9: single transfer ignores cmd_len
        feed[0] = 16'hBEEF;
        run_xfer(1'b0, 16'h1234, 4'd5);
        feed[0] = 16'h0000;
        run_xfer(1'b0, 16'hFFFF, 4'd0);
        feed[0] = 16'h8001;
        run_xfer(1'b0, 16'h0001, 4'd1);
        // R6 R7: block with address carry across a byte boundary
        for (int i = 0; i < 16; i++) feed[i] = DW'(16'h1000 + i * 16'h0111);
        run_xfer(1'b1, 16'h00FE, 4'd3);
        // R9: block length zero moves one word
        feed[0] = 16'hC3A5;
        run_xfer(1'b1, 16'h4000, 4'd0);
        // R7: block wraps at the top of the address space
        feed[0] = 16'h5A5A;
        feed[1] = 16'hF00F;
        run_xfer(1'b1, 16'hFFFF, 4'd2);
        // R6 R11: longest block
        for (int i = 0; i < 16; i++) feed[i] = DW'(16'hFFFF - i * 16'h0F0F);
        run_xfer(1'b1, 16'h2468, 4'd15);

        repeat (5) @(negedge clk);
        chk(wq_a.size() == 0, "R10", "writes outstanding", wq_a.size(), 0);
        chk(fq_a.size() == 0, "R8", "frames outstanding", fq_a.size(), 0);
        chk(bus_valid == 1'b0 && cmd_ready == 1'b1, "R10", "idle at end",
            32'(bus_valid), 0);
        finish_run();
    end

endmodule